// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block sits in front of a bank of 16-bit counter channels, three channels to a group and two groups by default. It gives every channel a one-cycle clock enable and a gate level. The counters that consume these signals are outside the block. Each channel holds two 5-bit selectors, one for its clock source and one for its gate source. A small write-only register bus loads the selectors.

Clock candidates are:
- the channel's own clock pin;
- the group's shared external clock;
- six internal timebase ticks divided from the 40 MHz system clock;
- the output of the channel before it, wired as a ring across groups;
- a pattern-match input;
- two constant levels.

Gate candidates are:
- constant enable and constant disable;
- the channel's gate pin, true or inverted;
- the output of the channel two places back, true or inverted;
- three pattern signals, each true or negated. They are the live match, a sticky "has occurred" latch, and a "has gone away" latch that falls once a match ends.

The block also tells the pad ring whether each clock pin and each gate pin is an input or is driven.

All pins, external clocks, counter outputs and the pattern input pass through a two-stage synchroniser. Each edge-type source is edge-detected separately, before selection. Outputs are registered.

Top module: `ccg_router`

## Requirements
- R1: While reset is held and immediately after it, every clock selector and every gate selector is 0, no clock enable is asserted, every gate output is high, every clock-pin output enable is low and every gate-pin output enable is high.
- R2: A write with address bit 3 clear loads the clock selector of the channel given by address bits 2:0. With bit 3 set it loads that channel's gate selector. Address 15 clears the pattern latches. Any other address (channel index 6 or 7 that is not 15) changes nothing.
- R3: Clock codes 11, 1, 2, 3, 4 and 5 give exactly one enable every 2, 4, 40, 400, 4000 and 40000 system cycles respectively.
- R4: Clock code 0 gives one enable per rising edge of the channel's own clock pin. Code 7 gives one enable per rising edge of its own group's external clock and ignores the other group's.
- R5: Clock code 6 counts rising edges of the output of channel n-1 in the same group for n>0. Channel 0 of a group uses channel 2 of the previous group, and the last group precedes the first.
- R6: Clock codes 8 and 9 give no enables. Code 10 gives one enable per rising edge of the pattern input. Codes 12 to 31 give no enables.
- R7: Gate code 0 gives high, 1 gives low, 2 follows the channel's gate pin and 6 follows its inverse.
- R8: Gate code 7 follows the output of channel n-2, and code 3 follows its inverse. Channel 2 of a group uses channel 0 of the same group. Channels 0 and 1 use channel n+1 of the previous group in the ring.
- R9: Gate code 8 follows the pattern input. Code 9 is a latch that goes high once the pattern has matched. Code 10 is a latch that is high until the pattern stops matching after it has occurred, then low. Codes 11, 12 and 13 are the inverses of 8, 9 and 10.
- R10: A clear write returns the two pattern latches to their inactive levels (occurred low, gone-away high). A clear takes priority over a set in the same cycle, so with the pattern held high the occurred latch reads low for exactly one cycle and then sets again.
- R11: Gate codes 4, 5 and 14 to 31 give a low gate.
- R12: A clock-pin output enable is high exactly when that channel's clock selector is non-zero. A gate-pin output enable is high exactly when that channel's gate selector is not 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: bit 3 selects gate or clock, bits 2:0 select the channel; 15 clears the latches |
| wr_data | input | 5 | Selector code |
| clk_pin_in | input | 6 | Per-channel clock pins |
| gat_pin_in | input | 6 | Per-channel gate pins |
| grp_ext_clk | input | 2 | Shared external clock, one per group |
| cnt_out | input | 6 | Counter outputs, one per channel |
| pat_match | input | 1 | Pattern-present input |
| clk_en | output | 6 | One-cycle clock enable per channel |
| gate | output | 6 | Gate level per channel |
| clk_pin_oe | output | 6 | High when the clock pin is driven rather than read |
| gat_pin_oe | output | 6 | High when the gate pin is driven rather than read |

## Verification
Two things can land in the same cycle: a clear-latch write, and the set condition of the pattern-occurred latch. The bench creates this overlap by holding the pattern input high and then issuing the clear. It then samples the code-12 and code-9 gate outputs on the two cycles that follow. The expected result is one cycle of the inactive level, then a re-set. A later fall of the pattern must still drop the gone-away latch, which shows that the re-set latch is fully active.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
    localparam int CH_PER_GRP = 3;
    localparam int SRC_W      = 5;
    localparam int N_TICK     = 6;   // 20M,10M,1M,100k,10k,1k

    // clock selector codes
    localparam logic [SRC_W-1:0] CK_PIN  = 5'd0;
    localparam logic [SRC_W-1:0] CK_10M  = 5'd1;
    localparam logic [SRC_W-1:0] CK_1M   = 5'd2;
    localparam logic [SRC_W-1:0] CK_100K = 5'd3;
    localparam logic [SRC_W-1:0] CK_10K  = 5'd4;
    localparam logic [SRC_W-1:0] CK_1K   = 5'd5;
    localparam logic [SRC_W-1:0] CK_PREV = 5'd6;
    localparam logic [SRC_W-1:0] CK_EXT  = 5'd7;
    localparam logic [SRC_W-1:0] CK_HI   = 5'd8;
    localparam logic [SRC_W-1:0] CK_LO   = 5'd9;
    localparam logic [SRC_W-1:0] CK_PAT  = 5'd10;
    localparam logic [SRC_W-1:0] CK_20M  = 5'd11;

    // gate selector codes
    localparam logic [SRC_W-1:0] GT_ON    = 5'd0;
    localparam logic [SRC_W-1:0] GT_OFF   = 5'd1;
    localparam logic [SRC_W-1:0] GT_PIN   = 5'd2;
    localparam logic [SRC_W-1:0] GT_NOUT2 = 5'd3;
    localparam logic [SRC_W-1:0] GT_NPIN  = 5'd6;
    localparam logic [SRC_W-1:0] GT_OUT2  = 5'd7;
    localparam logic [SRC_W-1:0] GT_PAT   = 5'd8;
    localparam logic [SRC_W-1:0] GT_OCC   = 5'd9;
    localparam logic [SRC_W-1:0] GT_GONE  = 5'd10;
    localparam logic [SRC_W-1:0] GT_NPAT  = 5'd11;
    localparam logic [SRC_W-1:0] GT_NOCC  = 5'd12;
    localparam logic [SRC_W-1:0] GT_NGONE = 5'd13;
endpackage

// File: rtl/ccg_timebase.sv
module ccg_timebase
    import ccg_pkg::*;
#(
    parameter int SYS_PER_FAST = 2,   // system cycles per fastest tick
    parameter int DEC          = 10   // ratio between slower ticks
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [N_TICK-1:0] tick_o
);
    localparam int PRE_MAX = 2 * SYS_PER_FAST - 1;
    localparam int PRE_W   = $clog2(PRE_MAX + 1);
    localparam int DEC_W   = $clog2(DEC);
    localparam int N_DEC   = N_TICK - 2;

    typedef struct packed {
        logic [PRE_W-1:0]            pre;
        logic [N_DEC-1:0][DEC_W-1:0] dec;
        logic [N_TICK-1:0]           tick;
    } tb_st_t;

    tb_st_t st_d, st_q;

    always_comb begin
        logic carry;
        st_d     = st_q;
        st_d.pre = (st_q.pre == PRE_W'(PRE_MAX)) ? '0 : st_q.pre + 1'b1;
        carry    = (st_q.pre == PRE_W'(PRE_MAX));
        st_d.tick[0] = carry || (st_q.pre == PRE_W'(SYS_PER_FAST - 1));
        st_d.tick[1] = carry;
        for (int k = 0; k < N_DEC; k++) begin
            if (carry)
                st_d.dec[k] = (st_q.dec[k] == DEC_W'(DEC - 1)) ? '0 : st_q.dec[k] + 1'b1;
            carry = carry && (st_q.dec[k] == DEC_W'(DEC - 1));
            st_d.tick[k+2] = carry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    a_r3_fast_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[0] |=> !tick_o[0]);
    a_r3_slow_nested: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[2] |-> (tick_o[1] && tick_o[0]));
endmodule

// File: rtl/ccg_sync_edge.sv
module ccg_sync_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } se_st_t;

    se_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.s2;
    assign rise_o = st_q.s2 & ~st_q.s3;

    // R4: an edge enable never lasts two cycles
    a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o & $past(rise_o)) == '0);
endmodule

// File: rtl/ccg_pat_latch.sv
module ccg_pat_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pat_i,
    input  logic clr_i,
    output logic occ_o,
    output logic gone_o
);
    typedef struct packed {
        logic occ;
        logic gone;
    } pl_st_t;

    pl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.occ  = 1'b0;
            st_d.gone = 1'b1;
        end else begin
            st_d.occ  = st_q.occ | pat_i;
            st_d.gone = st_q.gone & ~(st_q.occ & ~pat_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{occ: 1'b0, gone: 1'b1};
        else        st_q <= st_d;
    end

    assign occ_o  = st_q.occ;
    assign gone_o = st_q.gone;

    a_r9_gone_needs_occ: assert property (@(posedge clk) disable iff (!rst_n)
        !gone_o |-> occ_o);
    a_r10_occ_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_o && !clr_i) |=> occ_o);
endmodule

// File: rtl/ccg_router.sv
module ccg_router
    import ccg_pkg::*;
#(
    parameter int N_GRP        = 2,
    parameter int SYS_PER_FAST = 2,
    parameter int DEC          = 10,
    localparam int N_CH   = N_GRP * CH_PER_GRP,
    localparam int IDX_W  = $clog2(N_CH + 1),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SRC_W-1:0]  wr_data,
    input  logic [N_CH-1:0]   clk_pin_in,
    input  logic [N_CH-1:0]   gat_pin_in,
    input  logic [N_GRP-1:0]  grp_ext_clk,
    input  logic [N_CH-1:0]   cnt_out,
    input  logic              pat_match,
    output logic [N_CH-1:0]   clk_en,
    output logic [N_CH-1:0]   gate,
    output logic [N_CH-1:0]   clk_pin_oe,
    output logic [N_CH-1:0]   gat_pin_oe
);
    localparam int SYNC_W = 3 * N_CH + N_GRP + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CH - 1);
    localparam logic [IDX_W-1:0] CLR_IDX  = '1;

    typedef struct packed {
        logic [N_CH-1:0][SRC_W-1:0] csrc;
        logic [N_CH-1:0][SRC_W-1:0] gsrc;
        logic [N_CH-1:0]            en;
        logic [N_CH-1:0]            gate;
    } rt_st_t;

    rt_st_t st_d, st_q;

    // ring neighbours
    function automatic int prev_clk_ch(int i);
        int g = i / CH_PER_GRP;
        int n = i % CH_PER_GRP;
        if (n > 0) return i - 1;
        return ((g + N_GRP - 1) % N_GRP) * CH_PER_GRP + (CH_PER_GRP - 1);
    endfunction

    function automatic int back2_ch(int i);
        int g = i / CH_PER_GRP;
        int n = i % CH_PER_GRP;
        if (n == 2) return g * CH_PER_GRP;
        return ((g + N_GRP - 1) % N_GRP) * CH_PER_GRP + n + 1;
    endfunction

    logic [N_TICK-1:0] tick;
    logic [SYNC_W-1:0] s_lvl, s_rise;
    logic              occ, gone, clr;

    ccg_timebase #(.SYS_PER_FAST(SYS_PER_FAST), .DEC(DEC)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    ccg_sync_edge #(.W(SYNC_W)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({pat_match, grp_ext_clk, cnt_out, gat_pin_in, clk_pin_in}),
        .lvl_o(s_lvl), .rise_o(s_rise)
    );

    logic [N_CH-1:0]  cpin_rise, gpin_lvl, out_lvl, out_rise;
    logic [N_GRP-1:0] ext_rise;
    logic             pat_lvl, pat_rise;
    logic             unused_sync;

    assign cpin_rise = s_rise[N_CH-1:0];
    assign gpin_lvl  = s_lvl[2*N_CH-1:N_CH];
    assign out_lvl   = s_lvl[3*N_CH-1:2*N_CH];
    assign out_rise  = s_rise[3*N_CH-1:2*N_CH];
    assign ext_rise  = s_rise[3*N_CH+N_GRP-1:3*N_CH];
    assign pat_lvl   = s_lvl[SYNC_W-1];
    assign pat_rise  = s_rise[SYNC_W-1];
    assign unused_sync = ^{s_lvl[N_CH-1:0], s_rise[2*N_CH-1:N_CH],
                           s_lvl[3*N_CH+N_GRP-1:3*N_CH]};

    ccg_pat_latch u_latch (
        .clk(clk), .rst_n(rst_n), .pat_i(pat_lvl), .clr_i(clr),
        .occ_o(occ), .gone_o(gone)
    );

    always_comb begin
        logic [IDX_W-1:0] idx;
        st_d = st_q;
        clr  = 1'b0;
        idx  = wr_addr[IDX_W-1:0];
        if (wr_en) begin
            if (!wr_addr[ADDR_W-1]) begin
                if (idx <= LAST_IDX) st_d.csrc[idx] = wr_data;
            end else if (idx <= LAST_IDX) begin
                st_d.gsrc[idx] = wr_data;
            end else if (idx == CLR_IDX) begin
                clr = 1'b1;
            end
        end
        for (int i = 0; i < N_CH; i++) begin
            case (st_q.csrc[i])
                CK_PIN:  st_d.en[i] = cpin_rise[i];
                CK_10M:  st_d.en[i] = tick[1];
                CK_1M:   st_d.en[i] = tick[2];
                CK_100K: st_d.en[i] = tick[3];
                CK_10K:  st_d.en[i] = tick[4];
                CK_1K:   st_d.en[i] = tick[5];
                CK_PREV: st_d.en[i] = out_rise[prev_clk_ch(i)];
                CK_EXT:  st_d.en[i] = ext_rise[i / CH_PER_GRP];
                CK_PAT:  st_d.en[i] = pat_rise;
                CK_20M:  st_d.en[i] = tick[0];
                default: st_d.en[i] = 1'b0;   // constants and reserved
            endcase
            case (st_q.gsrc[i])
                GT_ON:    st_d.gate[i] = 1'b1;
                GT_OFF:   st_d.gate[i] = 1'b0;
                GT_PIN:   st_d.gate[i] = gpin_lvl[i];
                GT_NPIN:  st_d.gate[i] = ~gpin_lvl[i];
                GT_NOUT2: st_d.gate[i] = ~out_lvl[back2_ch(i)];
                GT_OUT2:  st_d.gate[i] = out_lvl[back2_ch(i)];
                GT_PAT:   st_d.gate[i] = pat_lvl;
                GT_OCC:   st_d.gate[i] = occ;
                GT_GONE:  st_d.gate[i] = gone;
                GT_NPAT:  st_d.gate[i] = ~pat_lvl;
                GT_NOCC:  st_d.gate[i] = ~occ;
                GT_NGONE: st_d.gate[i] = ~gone;
                default:  st_d.gate[i] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{csrc: '0, gsrc: '0, en: '0, gate: '1};
        else        st_q <= st_d;
    end

    assign clk_en = st_q.en;
    assign gate   = st_q.gate;

    for (genvar i = 0; i < N_CH; i++) begin : g_dir
        assign clk_pin_oe[i] = (st_q.csrc[i] != CK_PIN);
        assign gat_pin_oe[i] = (st_q.gsrc[i] != GT_PIN);

        // R6: constant and reserved clock codes never produce an enable
        a_r6_no_clk_reserved: assert property (@(posedge clk) disable iff (!rst_n)
            clk_en[i] |-> ($past(st_q.csrc[i]) <= CK_20M &&
                           $past(st_q.csrc[i]) != CK_HI &&
                           $past(st_q.csrc[i]) != CK_LO));
        // R11: reserved gate codes hold the gate low
        a_r11_gate_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
            gate[i] |-> ($past(st_q.gsrc[i]) <= GT_NGONE &&
                         $past(st_q.gsrc[i]) != 5'd4 &&
                         $past(st_q.gsrc[i]) != 5'd5));
    end
endmodule

// File: tb/ccg_router_tb.sv
module ccg_router_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [4:0] wr_data = '0;
    logic [5:0] cpin = '0, gpin = '0, cnt = '0;
    logic [1:0] ext = '0;
    logic       pat = 1'b0;
    logic [5:0] clk_en, gate, clk_pin_oe, gat_pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    int pc [6];

    always #5 clk = ~clk;

    ccg_router u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clk_pin_in(cpin), .gat_pin_in(gpin),
        .grp_ext_clk(ext), .cnt_out(cnt), .pat_match(pat),
        .clk_en(clk_en), .gate(gate), .clk_pin_oe(clk_pin_oe),
        .gat_pin_oe(gat_pin_oe)
    );

    initial for (int i = 0; i < 6; i++) pc[i] = 0;
    always @(negedge clk)
        for (int i = 0; i < 6; i++) if (clk_en[i] === 1'b1) pc[i] = pc[i] + 1;

    // {tag[22:21], ch[20:18], gsrc[17:13], gat[12:7], cnt[6:1], exp[0]}
    localparam logic [22:0] VEC [18] = '{
        {2'd0, 3'd0, 5'd0,  6'h00, 6'h00, 1'b1},  // R7 on
        {2'd0, 3'd0, 5'd1,  6'h3f, 6'h3f, 1'b0},  // R7 off
        {2'd0, 3'd1, 5'd2,  6'h02, 6'h00, 1'b1},  // R7 pin
        {2'd0, 3'd1, 5'd2,  6'h00, 6'h00, 1'b0},  // R7 pin
        {2'd0, 3'd1, 5'd6,  6'h00, 6'h00, 1'b1},  // R7 inverted pin
        {2'd0, 3'd1, 5'd6,  6'h02, 6'h00, 1'b0},  // R7 inverted pin
        {2'd1, 3'd2, 5'd3,  6'h00, 6'h01, 1'b0},  // R8 ch2 <- ~ch0
        {2'd1, 3'd2, 5'd7,  6'h00, 6'h01, 1'b1},  // R8 ch2 <- ch0
        {2'd1, 3'd0, 5'd7,  6'h00, 6'h10, 1'b1},  // R8 ch0 <- ch4
        {2'd1, 3'd0, 5'd7,  6'h00, 6'h2f, 1'b0},  // R8 ch0 ignores others
        {2'd1, 3'd1, 5'd7,  6'h00, 6'h20, 1'b1},  // R8 ch1 <- ch5
        {2'd1, 3'd3, 5'd7,  6'h00, 6'h02, 1'b1},  // R8 ch3 <- ch1
        {2'd1, 3'd5, 5'd3,  6'h00, 6'h08, 1'b0},  // R8 ch5 <- ~ch3
        {2'd1, 3'd5, 5'd3,  6'h00, 6'h37, 1'b1},  // R8 ch5 <- ~ch3
        {2'd2, 3'd4, 5'd4,  6'h3f, 6'h3f, 1'b0},  // R11
        {2'd2, 3'd4, 5'd5,  6'h3f, 6'h3f, 1'b0},  // R11
        {2'd2, 3'd4, 5'd20, 6'h3f, 6'h3f, 1'b0},  // R11
        {2'd2, 3'd4, 5'd31, 6'h3f, 6'h3f, 1'b0}   // R11
    };

    function automatic string tag_of(logic [1:0] t);
        case (t)
            2'd0:    return "R7";
            2'd1:    return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [4:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(int kind, int b, int n);
        for (int k = 0; k < n; k++) begin
            case (kind)
                0: cpin[b] = 1'b1;
                1: ext[b]  = 1'b1;
                2: cnt[b]  = 1'b1;
                default: pat = 1'b1;
            endcase
            repeat (3) @(negedge clk);
            case (kind)
                0: cpin[b] = 1'b0;
                1: ext[b]  = 1'b0;
                2: cnt[b]  = 1'b0;
                default: pat = 1'b0;
            endcase
            repeat (3) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic win(int ch, int cyc, output int n);
        int b;
        repeat (10) @(negedge clk);
        b = pc[ch];
        repeat (cyc) @(negedge clk);
        n = pc[ch] - b;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n, b0, b1;
        logic [5:0] g_snap, o_snap;
        repeat (4) @(negedge clk);
        chk("R1", gate, 6'h3f);
        chk("R1", clk_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", gate, 6'h3f);
        chk("R1", clk_pin_oe, 0);
        chk("R1", gat_pin_oe, 6'h3f);
        repeat (5) @(negedge clk);
        chk("R1", clk_en, 0);

        // gate routing table
        for (int v = 0; v < 18; v++) begin
            logic [22:0] e;
            e = VEC[v];
            gpin = e[12:7];
            cnt  = e[6:1];
            wr({1'b1, e[20:18]}, e[17:13]);
            repeat (6) @(negedge clk);
            chk(tag_of(e[22:21]), gate[e[20:18]], e[0]);
        end
        gpin = '0; cnt = '0;
        for (int c = 0; c < 6; c++) wr(4'(8 + c), 5'd0);

        // R3 internal timebases on channel 0
        wr(4'd0, 5'd11); win(0, 400, n);   chk("R3", n, 200);
        wr(4'd0, 5'd1);  win(0, 400, n);   chk("R3", n, 100);
        wr(4'd0, 5'd2);  win(0, 400, n);   chk("R3", n, 10);
        wr(4'd0, 5'd3);  win(0, 800, n);   chk("R3", n, 2);
        wr(4'd0, 5'd4);  win(0, 4000, n);  chk("R3", n, 1);
        wr(4'd0, 5'd5);  win(0, 40000, n); chk("R3", n, 1);

        // R4 own pin and group clock
        b0 = pc[2]; pulse(0, 2, 3); chk("R4", pc[2] - b0, 3);
        wr(4'd4, 5'd7); wr(4'd1, 5'd7);
        b0 = pc[4]; b1 = pc[1]; pulse(1, 1, 2);
        chk("R4", pc[4] - b0, 2); chk("R4", pc[1] - b1, 0);
        b0 = pc[4]; b1 = pc[1]; pulse(1, 0, 2);
        chk("R4", pc[4] - b0, 0); chk("R4", pc[1] - b1, 2);

        // R5 ring of preceding outputs
        wr(4'd3, 5'd6); wr(4'd0, 5'd6);
        b0 = pc[3]; pulse(2, 2, 2); chk("R5", pc[3] - b0, 2);
        b0 = pc[0]; pulse(2, 5, 2); chk("R5", pc[0] - b0, 2);
        b0 = pc[0]; pulse(2, 1, 2); chk("R5", pc[0] - b0, 0);

        // R6 constants, pattern and reserved clock codes
        wr(4'd0, 5'd8);  b0 = pc[0]; pulse(3, 0, 2); chk("R6", pc[0] - b0, 0);
        wr(4'd0, 5'd9);  win(0, 200, n); chk("R6", n, 0);
        wr(4'd0, 5'd10); b0 = pc[0]; pulse(3, 0, 2); chk("R6", pc[0] - b0, 2);
        wr(4'd0, 5'd12); win(0, 400, n); chk("R6", n, 0);
        wr(4'd0, 5'd31); win(0, 400, n); chk("R6", n, 0);

        // R12 pin directions
        for (int c = 0; c < 6; c++) wr(4'(c), 5'd0);
        wr(4'd5, 5'd1); wr(4'd9, 5'd2);
        @(negedge clk);
        chk("R12", clk_pin_oe, 6'h20);
        chk("R12", gat_pin_oe, 6'h3d);

        // R2 writes to unused channel indices change nothing
        g_snap = gate; o_snap = clk_pin_oe;
        wr(4'd6, 5'd11); wr(4'd7, 5'd11); wr(4'd14, 5'd1);
        repeat (4) @(negedge clk);
        chk("R2", gate, g_snap);
        chk("R2", clk_pin_oe, o_snap);
        chk("R2", gat_pin_oe, 6'h3d);

        // R9 pattern gates: ch0..5 codes 11,12,13,8,9,10
        wr(4'd8, 5'd11); wr(4'd9, 5'd12); wr(4'd10, 5'd13);
        wr(4'd11, 5'd8); wr(4'd12, 5'd9); wr(4'd13, 5'd10);
        wr(4'd15, 5'd0);
        repeat (6) @(negedge clk); chk("R9", gate, 6'h23);
        pat = 1'b1; repeat (6) @(negedge clk); chk("R9", gate, 6'h38);
        pat = 1'b0; repeat (6) @(negedge clk); chk("R9", gate, 6'h15);

        // R10 clear, then clear against a present pattern
        wr(4'd15, 5'd0); repeat (6) @(negedge clk); chk("R10", gate, 6'h23);
        pat = 1'b1; repeat (6) @(negedge clk); chk("R10", gate, 6'h38);
        wr(4'd15, 5'd0);
        @(negedge clk); chk("R10", gate[4], 0); chk("R10", gate[1], 1);
        @(negedge clk); chk("R10", gate[4], 1); chk("R10", gate[1], 0);
        repeat (4) @(negedge clk); chk("R10", gate, 6'h38);
        pat = 1'b0; repeat (6) @(negedge clk); chk("R10", gate, 6'h15);

        finish_run();
    end
endmodule